// File: doc/BRIEF.md
# Floating-Point to Fixed-Point Converter

This block turns a half, single or double precision floating-point operand into a 16-bit or 32-bit fixed-point integer. The integer can be signed or unsigned, and the number of fraction bits is programmable. The operand is first scaled by two to the power of the fraction count. It is then truncated toward zero, clamped to the range of the fixed-point type, and widened to the destination: 32 bits for half and single inputs, 64 bits for double inputs. The same result also reports an invalid-operation flag and an inexact flag.

The fraction count is not supplied directly. A 5-bit code gives the fixed width minus the fraction count, so the block subtracts that code from the width itself. An illegal format selector raises a separate encoding-error flag, and so does a code that would make the fraction count negative. The datapath is combinational and has one register stage at the output. An input presented with `in_valid` produces its result on the next clock edge.

Top module: `fxcvt_top`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid`, `result`, `bad_enc`, `flag_invalid` and `flag_inexact` take the values for that input at that edge. When `in_valid` is low, `out_valid` goes low at the next edge and the other outputs keep their values.
- R2: `fmt` selects the input format. 2'b01 is half precision in `operand[15:0]`, 2'b10 is single precision in `operand[31:0]`, and 2'b11 is double precision in `operand[63:0]`. Operand bits above the selected format have no effect. The value 2'b00 sets `bad_enc`.
- R3: The fixed width is 16 bits when `wide`=0 and 32 bits when `wide`=1. The fraction count is that width minus the unsigned value of `frac_code`. If the count would be negative (16-bit width and a code above 16), `bad_enc` is set. Whenever `bad_enc` is set, `result` is zero and both exception flags are clear.
- R4: The operand is multiplied by two to the power of the fraction count and truncated toward zero.
- R5: `flag_inexact` is set when truncation discards nonzero bits and the result did not saturate.
- R6: A value outside the fixed range saturates and sets `flag_invalid`. The limits are 2^(W-1)-1 and -2^(W-1) for signed, and 2^W-1 for unsigned. A value exactly equal to -2^(W-1) is representable.
- R7: A NaN operand gives a zero result and sets `flag_invalid`.
- R8: An infinity saturates toward its sign and sets `flag_invalid`.
- R9: A negative operand in an unsigned conversion gives zero. If truncation gives a nonzero magnitude, `flag_invalid` is set. If it truncates to zero, only `flag_inexact` is set.
- R10: A signed result is sign-extended and an unsigned result is zero-extended to the destination width. The destination is 32 bits for half and single inputs and 64 bits for double inputs. Bits above the destination are zero.
- R11: While `rst` is high, all registered outputs are zero.
- R12: `flag_invalid` and `flag_inexact` are never set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the operand and controls for this cycle |
| operand | input | 64 | Floating-point operand, low-aligned |
| fmt | input | 2 | Format selector: 01 half, 10 single, 11 double |
| is_unsigned | input | 1 | 1 selects an unsigned fixed-point result |
| wide | input | 1 | 0 selects a 16-bit fixed value, 1 a 32-bit one |
| frac_code | input | 5 | Fixed width minus fraction count |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| result | output | 64 | Extended fixed-point result |
| bad_enc | output | 1 | Illegal format or negative fraction count |
| flag_invalid | output | 1 | Invalid-operation exception |
| flag_inexact | output | 1 | Inexact exception |

## Verification
Every result is due exactly one rising edge after the edge that samples `in_valid`. The bench drives each vector on a falling edge and compares all four result outputs on the next falling edge, after the single register stage has loaded. Idle cycles are inserted with new operand values to show that the outputs stay unchanged while `in_valid` is low. Expected values come from a real-number model of scaling and truncation that is separate from the design's shifter.

// File: rtl/fxcvt_pkg.sv
package fxcvt_pkg;

    localparam int OP_W   = 64;
    localparam int MANT_W = 53;
    localparam int EXP_W  = 13;
    localparam int FB_W   = 6;
    localparam int NARROW_W = 16;
    localparam int BROAD_W  = 32;
    localparam int NFMT   = 3;

    typedef enum logic [1:0] {
        FMT_NONE   = 2'b00,
        FMT_HALF   = 2'b01,
        FMT_SINGLE = 2'b10,
        FMT_DOUBLE = 2'b11
    } fmt_e;

    // Common unpacked form: value = mant * 2^(exp - (MANT_W-1)).
    typedef struct packed {
        logic                    sign;
        logic                    nan;
        logic                    inf;
        logic                    zero;
        logic [EXP_W-1:0]        exp;
        logic [MANT_W-1:0]       mant;
    } unpacked_t;

    typedef struct packed {
        logic [MANT_W-1:0] mag;
        logic              lost;
        logic              huge;
    } trunc_t;

    typedef struct packed {
        logic [OP_W-1:0] value;
        logic            invalid;
        logic            inexact;
    } conv_t;

    function automatic int fmt_exp_w(input int idx);
        case (idx)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int fmt_frac_w(input int idx);
        case (idx)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

endpackage

// File: rtl/fxcvt_field_unpack.sv
module fxcvt_field_unpack
    import fxcvt_pkg::*;
#(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [EW+FW:0] bits,
    output unpacked_t      u
);
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam logic [EXP_W-1:0] BIAS_V = EXP_W'(BIAS);

    logic [EW-1:0] e;
    logic [FW-1:0] f;
    logic          e_ones;
    logic          e_zero;

    always_comb begin
        e      = bits[EW+FW-1:FW];
        f      = bits[FW-1:0];
        e_ones = &e;
        e_zero = (e == '0);
        u.sign = bits[EW+FW];
        u.nan  = e_ones && (f != '0);
        u.inf  = e_ones && (f == '0);
        u.zero = e_zero && (f == '0);
        // Subnormals share the smallest normal exponent, without the hidden bit.
        u.exp  = e_zero ? (EXP_W'(1) - BIAS_V) : (EXP_W'(e) - BIAS_V);
        u.mant = MANT_W'({!e_zero, f}) << (MANT_W - 1 - FW);
    end
endmodule

// File: rtl/fxcvt_trunc.sv
module fxcvt_trunc
    import fxcvt_pkg::*;
(
    input  logic [EXP_W-1:0]  exp,
    input  logic [MANT_W-1:0] mant,
    input  logic              zero,
    input  logic [FB_W-1:0]   fbits,
    output trunc_t            t
);
    logic [EXP_W-1:0]  sh;
    logic [EXP_W-1:0]  rsh;
    logic [MANT_W-1:0] mask;

    always_comb begin
        // Binary point offset after scaling by 2^fbits.
        sh   = exp + EXP_W'(fbits) - EXP_W'(MANT_W - 1);
        rsh  = EXP_W'(0) - sh;
        mask = (MANT_W'(1) << rsh[5:0]) - MANT_W'(1);
        t    = '0;
        if (zero) begin
            t = '0;
        end else if (!sh[EXP_W-1]) begin
            // Non-negative offset: only normal inputs reach here, since the
            // largest fraction count cannot lift a subnormal exponent this far.
            // The magnitude is then at least 2^(MANT_W-1), beyond any target.
            t.huge = 1'b1;
            t.mag  = '1;
        end else if (rsh >= EXP_W'(MANT_W)) begin
            t.mag  = '0;
            t.lost = (mant != '0);
        end else begin
            t.mag  = mant >> rsh[5:0];
            t.lost = ((mant & mask) != '0);
        end
    end
endmodule

// File: rtl/fxcvt_saturate.sv
module fxcvt_saturate
    import fxcvt_pkg::*;
(
    input  logic   sign,
    input  logic   nan,
    input  logic   inf,
    input  logic   zero,
    input  trunc_t t,
    input  logic   is_unsigned,
    input  logic   wide,
    input  logic   dbl,
    output conv_t  c
);
    localparam logic [MANT_W-1:0] LIM_U_N = MANT_W'((64'd1 << NARROW_W) - 1);
    localparam logic [MANT_W-1:0] LIM_U_B = MANT_W'((64'd1 << BROAD_W) - 1);
    localparam logic [MANT_W-1:0] LIM_P_N = MANT_W'((64'd1 << (NARROW_W - 1)) - 1);
    localparam logic [MANT_W-1:0] LIM_P_B = MANT_W'((64'd1 << (BROAD_W - 1)) - 1);

    logic [MANT_W-1:0] lim_pos;
    logic [MANT_W-1:0] lim_neg;
    logic [OP_W-1:0]   sat_pos;
    logic [OP_W-1:0]   sat_neg;
    logic [OP_W-1:0]   fix64;
    logic              inv;
    logic              inx;

    always_comb begin
        lim_pos = is_unsigned ? (wide ? LIM_U_B : LIM_U_N)
                              : (wide ? LIM_P_B : LIM_P_N);
        lim_neg = (wide ? LIM_P_B : LIM_P_N) + MANT_W'(1);
        sat_pos = OP_W'(lim_pos);
        sat_neg = is_unsigned ? '0 : (OP_W'(0) - OP_W'(lim_neg));
        fix64   = '0;
        inv     = 1'b0;
        inx     = 1'b0;
        if (nan) begin
            inv = 1'b1;
        end else if (inf) begin
            fix64 = sign ? sat_neg : sat_pos;
            inv   = 1'b1;
        end else if (zero) begin
            fix64 = '0;
        end else if (sign && is_unsigned) begin
            if (!t.huge && t.mag == '0) inx = t.lost;
            else                        inv = 1'b1;
        end else if (sign) begin
            if (t.huge || t.mag > lim_neg) begin
                fix64 = sat_neg;
                inv   = 1'b1;
            end else begin
                fix64 = OP_W'(0) - OP_W'(t.mag);
                inx   = t.lost;
            end
        end else begin
            if (t.huge || t.mag > lim_pos) begin
                fix64 = sat_pos;
                inv   = 1'b1;
            end else begin
                fix64 = OP_W'(t.mag);
                inx   = t.lost;
            end
        end
        // fix64 is fully sign/zero extended; narrow destinations keep 32 bits.
        c.value   = dbl ? fix64 : {32'b0, fix64[31:0]};
        c.invalid = inv;
        c.inexact = inx;
    end
endmodule

// File: rtl/fxcvt_top.sv
module fxcvt_top
    import fxcvt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [63:0] operand,
    input  logic [1:0]  fmt,
    input  logic        is_unsigned,
    input  logic        wide,
    input  logic [4:0]  frac_code,
    output logic        out_valid,
    output logic [63:0] result,
    output logic        bad_enc,
    output logic        flag_invalid,
    output logic        flag_inexact
);
    logic signed [6:0] fb_s;
    logic [FB_W-1:0]   fbits;
    logic              bad_now;
    logic [1:0]        sel;
    unpacked_t         u_arr [NFMT];
    unpacked_t         u;
    trunc_t            tr;
    conv_t             cv;

    always_comb begin
        fb_s    = (wide ? 7'sd32 : 7'sd16) - $signed({2'b00, frac_code});
        fbits   = fb_s[FB_W-1:0];
        bad_now = (fmt_e'(fmt) == FMT_NONE) || fb_s[6];
        sel     = (fmt == 2'b00) ? 2'd0 : (fmt - 2'd1);
    end

    for (genvar g = 0; g < NFMT; g++) begin : g_fmt
        localparam int EW = fmt_exp_w(g);
        localparam int FW = fmt_frac_w(g);
        fxcvt_field_unpack #(.EW(EW), .FW(FW)) u_unpack (
            .bits (operand[EW+FW:0]),
            .u    (u_arr[g])
        );
    end

    always_comb u = u_arr[sel];

    fxcvt_trunc u_trunc (
        .exp   (u.exp),
        .mant  (u.mant),
        .zero  (u.zero),
        .fbits (fbits),
        .t     (tr)
    );

    fxcvt_saturate u_sat (
        .sign        (u.sign),
        .nan         (u.nan),
        .inf         (u.inf),
        .zero        (u.zero),
        .t           (tr),
        .is_unsigned (is_unsigned),
        .wide        (wide),
        .dbl         (fmt_e'(fmt) == FMT_DOUBLE),
        .c           (cv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            result       <= '0;
            bad_enc      <= 1'b0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                bad_enc      <= bad_now;
                result       <= bad_now ? '0 : cv.value;
                flag_invalid <= !bad_now && cv.invalid;
                flag_inexact <= !bad_now && cv.inexact;
            end
        end
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(result) && $stable(flag_invalid)
                      && $stable(flag_inexact) && $stable(bad_enc));
    assert_fmt_illegal_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid && fmt == 2'b00 |=> bad_enc && result == '0);
    assert_negfrac_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid && !wide && frac_code > 5'd16 |=> bad_enc && !flag_invalid && !flag_inexact);
    assert_nan_zero_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid && fmt == 2'b11 && (&operand[62:52]) && operand[51:0] != '0
        |=> result == '0 && flag_invalid);
    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid && fmt != 2'b11 |=> result[63:32] == '0);
    assert_unsigned_narrow_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid && is_unsigned && !wide && fmt != 2'b11 |=> result[63:16] == '0);
    assert_flags_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(flag_invalid && flag_inexact));
endmodule

// File: tb/test_fxcvt_top.sv
module test_fxcvt_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  fmt = 2'b01;
    logic        is_unsigned = 1'b0;
    logic        wide = 1'b0;
    logic [4:0]  frac_code = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        bad_enc;
    logic        flag_invalid;
    logic        flag_inexact;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fxcvt_top i_fxcvt_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
        .fmt(fmt), .is_unsigned(is_unsigned), .wide(wide), .frac_code(frac_code),
        .out_valid(out_valid), .result(result), .bad_enc(bad_enc),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    function automatic void model(input logic [63:0] op, input logic [1:0] f_sel,
                                  input logic uns, input logic wd, input logic [4:0] code,
                                  output logic [63:0] res, output logic bad,
                                  output logic inv, output logic inx);
        int     w, fb, e;
        longint fr, maxp, maxu, minmag, q, v, lim;
        logic   neg, isnan, isinf, big, exact;
        real    val, a;
        w = wd ? 32 : 16;
        fb = w - int'(code);
        res = '0; bad = 1'b0; inv = 1'b0; inx = 1'b0;
        if (f_sel == 2'b00 || fb < 0) begin
            bad = 1'b1;
            return;
        end
        val = 0.0;
        if (f_sel == 2'b01) begin
            neg = op[15]; e = int'(op[14:10]); fr = longint'(op[9:0]);
            isnan = (e == 31) && fr != 0; isinf = (e == 31) && fr == 0;
            if (e == 0) val = real'(fr) * 2.0 ** (-24);
            else        val = real'(fr + 1024) * 2.0 ** (e - 25);
        end else if (f_sel == 2'b10) begin
            neg = op[31]; e = int'(op[30:23]); fr = longint'(op[22:0]);
            isnan = (e == 255) && fr != 0; isinf = (e == 255) && fr == 0;
            if (e == 0) val = real'(fr) * 2.0 ** (-149);
            else        val = real'(fr + 64'd8388608) * 2.0 ** (e - 150);
        end else begin
            neg = op[63];
            isnan = (&op[62:52]) && op[51:0] != 0;
            isinf = (&op[62:52]) && op[51:0] == 0;
            if (!isnan && !isinf) val = $bitstoreal({1'b0, op[62:0]});
        end
        maxp   = (64'sd1 <<< (w - 1)) - 1;
        minmag = 64'sd1 <<< (w - 1);
        maxu   = (64'sd1 <<< w) - 1;
        v = 0;
        if (isnan) begin
            inv = 1'b1;
        end else if (isinf) begin
            inv = 1'b1;
            v = neg ? (uns ? 0 : -minmag) : (uns ? maxu : maxp);
        end else begin
            a = val * (2.0 ** fb);
            big = (a >= 2.0 ** 40);
            q = 0; exact = 1'b1;
            if (!big) begin
                q = longint'(a);
                if (real'(q) > a) q = q - 1;
                exact = (real'(q) == a);
            end
            if (neg && uns) begin
                if (!big && q == 0) inx = !exact;
                else                inv = 1'b1;
            end else if (neg) begin
                if (big || q > minmag) begin v = -minmag; inv = 1'b1; end
                else begin v = -q; inx = !exact; end
            end else begin
                lim = uns ? maxu : maxp;
                if (big || q > lim) begin v = lim; inv = 1'b1; end
                else begin v = q; inx = !exact; end
            end
        end
        res = (f_sel == 2'b11) ? 64'(v) : {32'b0, 32'(v)};
    endfunction

    task automatic check(input string tag, input logic [63:0] er, input logic eb,
                         input logic ei, input logic ex);
        n_vec++;
        if (out_valid !== 1'b1 || result !== er || bad_enc !== eb
            || flag_invalid !== ei || flag_inexact !== ex) begin
            n_bad++;
            $display("FAIL %s: got v=%b res=%h bad=%b inv=%b inx=%b, expected v=1 res=%h bad=%b inv=%b inx=%b",
                     tag, out_valid, result, bad_enc, flag_invalid, flag_inexact, er, eb, ei, ex);
        end
    endtask

    // Drive on a falling edge; the result is loaded on the next rising edge
    // and compared on the following falling edge.
    task automatic apply(input string tag, input logic [63:0] op, input logic [1:0] f_sel,
                         input logic uns, input logic wd, input logic [4:0] code);
        logic [63:0] er;
        logic eb, ei, ex;
        model(op, f_sel, uns, wd, code, er, eb, ei, ex);
        operand = op; fmt = f_sel; is_unsigned = uns; wide = wd; frac_code = code;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, er, eb, ei, ex);
    endtask

    function automatic logic [63:0] rand_op(input logic [1:0] f_sel);
        logic [63:0] r;
        r = {$urandom, $urandom};
        if ($urandom % 4 == 0) return r;
        case (f_sel)
            2'b01:   r[14:10] = 5'(15 + ($urandom % 24) - 16);
            2'b10:   r[30:23] = 8'(127 + ($urandom % 50) - 34);
            default: r[62:52] = 11'(1023 + ($urandom % 50) - 34);
        endcase
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R11: reset state
        n_vec++;
        if (out_valid !== 1'b0 || result !== '0 || bad_enc !== 1'b0
            || flag_invalid !== 1'b0 || flag_inexact !== 1'b0) begin
            n_bad++;
            $display("FAIL R11: got v=%b res=%h bad=%b inv=%b inx=%b, expected all zero",
                     out_valid, result, bad_enc, flag_invalid, flag_inexact);
        end
        rst = 1'b0;
        @(negedge clk);

        apply("R4", 64'h3FC0_0000, 2'b10, 1'b0, 1'b0, 5'd16);
        apply("R5", 64'h3FC0_0000, 2'b10, 1'b0, 1'b1, 5'd30);
        apply("R10", 64'hBFC0_0000, 2'b10, 1'b0, 1'b1, 5'd31);
        apply("R10", $realtobits(-2.5), 2'b11, 1'b0, 1'b1, 5'd31);
        apply("R6", 64'h3C00, 2'b01, 1'b1, 1'b0, 5'd0);
        apply("R6", 64'h471C_4000, 2'b10, 1'b0, 1'b0, 5'd16);
        apply("R6", $realtobits(-1.0e10), 2'b11, 1'b0, 1'b1, 5'd31);
        apply("R6", 64'hC700_0000, 2'b10, 1'b0, 1'b0, 5'd16);
        apply("R7", 64'h7FC0_0000, 2'b10, 1'b0, 1'b1, 5'd4);
        apply("R8", 64'h7FF0_0000_0000_0000, 2'b11, 1'b1, 1'b1, 5'd20);
        apply("R8", 64'hFC00, 2'b01, 1'b0, 1'b0, 5'd3);
        apply("R9", 64'hBE80_0000, 2'b10, 1'b1, 1'b0, 5'd16);
        apply("R9", 64'hBF80_0000, 2'b10, 1'b1, 1'b0, 5'd16);
        apply("R2", 64'h3F80_0000, 2'b00, 1'b0, 1'b1, 5'd4);
        apply("R2", 64'hDEAD_BEEF_1234_3C00, 2'b01, 1'b0, 1'b0, 5'd12);
        apply("R3", 64'h3C00, 2'b01, 1'b0, 1'b0, 5'd17);
        apply("R3", 64'h4A00, 2'b01, 1'b0, 1'b0, 5'd16);
        apply("R3", 64'h3F00_0000, 2'b10, 1'b1, 1'b1, 5'd0);

        // R1: outputs hold while in_valid is low, even as inputs change
        held = result;
        operand = 64'h4000_0000; fmt = 2'b10; frac_code = 5'd8;
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || result !== held) begin
            n_bad++;
            $display("FAIL R1: got v=%b res=%h, expected v=0 res=%h", out_valid, result, held);
        end

        for (int k = 0; k < N_RANDOM; k++) begin
            logic [1:0] fs;
            logic       wd;
            logic [4:0] code;
            fs   = 2'(1 + ($urandom % 3));
            if ($urandom % 40 == 0) fs = 2'b00;
            wd   = 1'($urandom);
            code = wd ? 5'($urandom) : 5'($urandom % 18);
            apply("R4", rand_op(fs), fs, 1'($urandom), wd, code);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule